// File: doc/BRIEF.md
# Level-Sensitive External Interrupt Flag Unit

This peripheral monitors eight active-low external interrupt pins. Each pin has its own enable bit in an 8-bit enable register. A pin that is enabled and held low raises a single shared request flag. The flag is sticky: it stays at 1 until software clears it, and it drives the one interrupt request line to the processor. Each pin first passes through a two-flop synchronizer. The detector only sees the synchronized level.

Software reaches the unit through a plain register port with an address, a write strobe, write data and combinational read data. The enable register sits at address 0x36 and reads back the last value written. The flag register sits at address 0x37 and uses only bit 0. Writing 0 to bit 0 clears the flag. Writing 1 to bit 0 changes nothing. If a clear and a qualifying low level fall in the same cycle, the set wins, so a pin that is still low raises the request again at once.

Top module: `lvl_irq_unit`

## Requirements
- R1: After reset the flag, the request output and the enable register are all 0.
- R2: A write to address 0x36 stores all eight data bits in the enable register. A read of 0x36 returns them, with bit n enabling pin n.
- R3: When a pin whose enable bit is 1 is held low, the flag becomes 1 on the third rising clock edge after the level is applied.
- R4: A low level on a pin whose enable bit is 0 never sets the flag.
- R5: Writing data with bit 0 equal to 0 to address 0x37 clears the flag at that clock edge, provided no enabled pin is low in its synchronized form.
- R6: Writing data with bit 0 equal to 1 to address 0x37 leaves the flag unchanged, whether the flag is 0 or 1.
- R7: Reading address 0x37 returns the flag in bit 0 and 0 in bits 7 to 1. Bits 7 to 1 of write data to 0x37 have no effect.
- R8: Once set, the flag stays 1 after the pins go high and after every enable bit is cleared, until software clears it.
- R9: When a clear write and an enabled low synchronized pin fall in the same cycle, the flag stays 1.
- R10: The request output always equals the flag bit.
- R11: Because of the two-flop synchronizer, the flag is still 0 two rising edges after an enabled pin goes low.
- R12: Reads of any other address return 0, and writes to any other address change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_n | input | 8 | Active-low external interrupt pins, asynchronous |
| reg_addr | input | 8 | Register address |
| reg_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_req | output | 1 | Interrupt request to the processor, registered |

## Verification
The assertions treat the synchronized pin vector and the enable register as the only set source. They assume the write strobe, address and data are stable around the sampling edge, so the decoded clear is seen as one clean cycle. The bench changes pins and register inputs only on falling edges, and it holds each pin level for at least three rising edges before it checks or clears. Every sampled level therefore reaches the detector before the next check. Sweeps cover all 256 enable values against each single low pin and against a computed multi-pin pattern. The expected flag is worked out in the bench as the OR of the enable bits ANDed with the inverted pin pattern.

// File: rtl/lvl_irq_pkg.sv
// Package: shared constants and types for the level-sensitive interrupt flag unit.
// Assumes the pin count never exceeds the register data width.
package lvl_irq_pkg;

    // Default geometry of the unit
    localparam int unsigned PIN_COUNT      = 8;
    localparam int unsigned REG_ADDR_W     = 8;
    localparam int unsigned REG_DATA_W     = 8;
    localparam int unsigned SYNC_STAGES    = 2;

    // Default register placement
    localparam logic [7:0] DEF_ENABLE_ADDR = 8'h36;
    localparam logic [7:0] DEF_FLAG_ADDR   = 8'h37;

    // Bit position of the shared flag inside its register
    localparam int unsigned FLAG_BIT       = 0;

    // Decoded register selection
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_FLAG   = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/lvl_irq_sync.sv
// Module: lvl_irq_sync
// Brings a vector of asynchronous pins into the clock domain through a
// chain of STAGES flops per bit. Resets every stage to RESET_VAL so that
// inactive (high) pins do not look active after reset.
// Assumes STAGES >= 2.
module lvl_irq_sync #(
    parameter int unsigned WIDTH     = 8,
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int unsigned LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Shift the pin level one stage deeper each clock.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RESET_VAL}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[b]};
            end
        end

        // The last stage is the synchronized pin level.
        assign sync_out[b] = chain_q[LAST];
    end

endmodule

// File: rtl/lvl_irq_regs.sv
// Module: lvl_irq_regs
// Register port of the unit: decodes the address, holds the per-pin enable
// register, produces a one-cycle clear request for the flag and drives the
// read data. Unused read bits are driven 0.
// Assumes NUM_PINS <= DATA_W and ENABLE_ADDR != FLAG_ADDR.
module lvl_irq_regs
    import lvl_irq_pkg::*;
#(
    parameter int unsigned        NUM_PINS    = PIN_COUNT,
    parameter int unsigned        ADDR_W      = REG_ADDR_W,
    parameter int unsigned        DATA_W      = REG_DATA_W,
    parameter logic [ADDR_W-1:0]  ENABLE_ADDR = ADDR_W'(DEF_ENABLE_ADDR),
    parameter logic [ADDR_W-1:0]  FLAG_ADDR   = ADDR_W'(DEF_FLAG_ADDR)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr_en,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                flag_q,
    output logic [NUM_PINS-1:0] enable_q,
    output logic                flag_clr_req,
    output logic [DATA_W-1:0]   reg_rdata
);

    reg_sel_e sel;

    // Map the address onto one of the two registers.
    always_comb begin
        if (reg_addr == ENABLE_ADDR) begin
            sel = SEL_ENABLE;
        end else if (reg_addr == FLAG_ADDR) begin
            sel = SEL_FLAG;
        end else begin
            sel = SEL_NONE;
        end
    end

    // Hold the per-pin enable bits written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (reg_wr_en && (sel == SEL_ENABLE)) begin
            enable_q <= reg_wdata[NUM_PINS-1:0];
        end
    end

    // Only a zero in the flag bit of a flag write asks for a clear.
    always_comb begin
        flag_clr_req = reg_wr_en && (sel == SEL_FLAG) && !reg_wdata[FLAG_BIT];
    end

    // Return the selected register, with unused bits at zero.
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_ENABLE: reg_rdata[NUM_PINS-1:0] = enable_q;
            SEL_FLAG:   reg_rdata[FLAG_BIT]     = flag_q;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/lvl_irq_flag.sv
// Module: lvl_irq_flag
// Level detector and sticky shared flag. Any synchronized low pin whose
// enable bit is set makes the flag 1. A clear request drops it only when
// no set condition is present in the same cycle.
// Assumes pin_sync is already in the clock domain.
module lvl_irq_flag #(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_sync,
    input  logic [NUM_PINS-1:0] enable_q,
    input  logic                flag_clr_req,
    output logic                flag_q
);

    logic [NUM_PINS-1:0] hit_vec;
    logic                set_hit;

    // Qualify each active-low pin with its enable bit.
    always_comb begin
        hit_vec = ~pin_sync & enable_q;
        set_hit = |hit_vec;
    end

    // Sticky flag: set has priority over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_hit) begin
            flag_q <= 1'b1;
        end else if (flag_clr_req) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/lvl_irq_unit.sv
// Module: lvl_irq_unit (top)
// Eight active-low interrupt pins, each enabled by its own bit, feed one
// sticky request flag that drives the processor request line directly.
// Assumes the register port inputs are synchronous to clk.
module lvl_irq_unit
    import lvl_irq_pkg::*;
#(
    parameter int unsigned        NUM_PINS    = PIN_COUNT,
    parameter int unsigned        ADDR_W      = REG_ADDR_W,
    parameter int unsigned        DATA_W      = REG_DATA_W,
    parameter int unsigned        SYNC_DEPTH  = SYNC_STAGES,
    parameter logic [ADDR_W-1:0]  ENABLE_ADDR = ADDR_W'(DEF_ENABLE_ADDR),
    parameter logic [ADDR_W-1:0]  FLAG_ADDR   = ADDR_W'(DEF_FLAG_ADDR)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] irq_pin_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr_en,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq_req
);

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] enable_q;
    logic                flag_clr_req;
    logic                flag_q;

    lvl_irq_sync #(
        .WIDTH     (NUM_PINS),
        .STAGES    (SYNC_DEPTH),
        .RESET_VAL (1'b1)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_pin_n),
        .sync_out (pin_sync)
    );

    lvl_irq_regs #(
        .NUM_PINS    (NUM_PINS),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .ENABLE_ADDR (ENABLE_ADDR),
        .FLAG_ADDR   (FLAG_ADDR)
    ) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wr_en    (reg_wr_en),
        .reg_wdata    (reg_wdata),
        .flag_q       (flag_q),
        .enable_q     (enable_q),
        .flag_clr_req (flag_clr_req),
        .reg_rdata    (reg_rdata)
    );

    lvl_irq_flag #(
        .NUM_PINS (NUM_PINS)
    ) flag_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_sync     (pin_sync),
        .enable_q     (enable_q),
        .flag_clr_req (flag_clr_req),
        .flag_q       (flag_q)
    );

    // The request line is the registered flag itself.
    assign irq_req = flag_q;

endmodule

// File: rtl/lvl_irq_unit_chk.sv
// Module: lvl_irq_unit_chk
// Temporal checks on the flag unit, attached to every lvl_irq_unit by bind.
// Assumes the register port inputs are stable around each rising edge.
module lvl_irq_unit_chk #(
    parameter int unsigned       NUM_PINS  = 8,
    parameter int unsigned       ADDR_W    = 8,
    parameter int unsigned       DATA_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h37
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_sync,
    input logic [NUM_PINS-1:0] enable_q,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_wr_en,
    input logic                wr_bit0,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic                irq_req
);

    logic hit;
    logic clr;

    // Observed set and clear conditions.
    always_comb begin
        hit = |(~pin_sync & enable_q);
        clr = reg_wr_en && (reg_addr == FLAG_ADDR) && !wr_bit0;
    end

    // R3
    set_on_enabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> irq_req);

    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && !hit) |=> !irq_req);

    // R5
    clear_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !irq_req);

    // R8
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !clr) |=> irq_req);

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr) |=> irq_req);

    // R7
    flag_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == FLAG_ADDR) |-> (reg_rdata == DATA_W'(irq_req)));

endmodule

bind lvl_irq_unit lvl_irq_unit_chk #(
    .NUM_PINS  (NUM_PINS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .FLAG_ADDR (FLAG_ADDR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_sync  (pin_sync),
    .enable_q  (enable_q),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .wr_bit0   (reg_wdata[0]),
    .reg_rdata (reg_rdata),
    .irq_req   (irq_req)
);

// File: tb/lvl_irq_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps enable values against single-pin and multi-pin low patterns
// and runs directed cases for clear, set priority, stickiness and decode.
module lvl_irq_unit_tb_top;

    localparam logic [7:0] EN_ADDR = 8'h36;
    localparam logic [7:0] FL_ADDR = 8'h37;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_pin_n = 8'hFF;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_req;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    lvl_irq_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_pin_n (irq_pin_n),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req)
    );

    // Compare and count one result.
    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One register write, committed at the rising edge between two falling edges.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Combinational register read, away from the clock edge.
    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        logic [7:0] rv;
        logic [7:0] pat;
        logic       exp_f;

        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);

        // R1: reset state
        check("R1 irq_req", {7'd0, irq_req}, 8'h00);
        rd(EN_ADDR, rv); check("R1 enable", rv, 8'h00);
        rd(FL_ADDR, rv); check("R1 flag", rv, 8'h00);

        // R2: enable register readback
        wr(EN_ADDR, 8'hA5); rd(EN_ADDR, rv); check("R2 readback A5", rv, 8'hA5);
        wr(EN_ADDR, 8'h5A); rd(EN_ADDR, rv); check("R2 readback 5A", rv, 8'h5A);

        // R12: other addresses
        wr(8'h10, 8'hFF); rd(EN_ADDR, rv); check("R12 enable untouched", rv, 8'h5A);
        rd(8'h10, rv); check("R12 other read zero", rv, 8'h00);

        // R11 / R3: synchronizer latency with pin 1 enabled
        wr(EN_ADDR, 8'h02);
        @(negedge clk); irq_pin_n = 8'hFD;
        wait_neg(2); check("R11 flag still low", {7'd0, irq_req}, 8'h00);
        wait_neg(1); check("R3 flag after third edge", {7'd0, irq_req}, 8'h01);

        // R7 / R6: read layout and writes of 1
        rd(FL_ADDR, rv); check("R7 flag read", rv, 8'h01);
        irq_pin_n = 8'hFF; wait_neg(3);
        wr(FL_ADDR, 8'hFF); check("R6 write one keeps flag", {7'd0, irq_req}, 8'h01);
        wr(FL_ADDR, 8'h01); rd(FL_ADDR, rv); check("R7 upper bits ignored", rv, 8'h01);

        // R5: clear with upper bits set
        wr(FL_ADDR, 8'hFE); check("R5 clear", {7'd0, irq_req}, 8'h00);
        wr(FL_ADDR, 8'h01); check("R6 write one keeps zero", {7'd0, irq_req}, 8'h00);

        // R9: set wins over clear while pin 0 stays low
        wr(EN_ADDR, 8'h01);
        @(negedge clk); irq_pin_n = 8'hFE; wait_neg(3);
        wr(FL_ADDR, 8'h00); check("R9 set beats clear", {7'd0, irq_req}, 8'h01);

        // R8: sticky after pin release and enables off
        irq_pin_n = 8'hFF; wait_neg(3);
        wr(EN_ADDR, 8'h00); wait_neg(5);
        check("R8 sticky irq", {7'd0, irq_req}, 8'h01);
        rd(FL_ADDR, rv); check("R8 sticky flag", rv, 8'h01);
        wr(FL_ADDR, 8'h00); check("R5 clear after sticky", {7'd0, irq_req}, 8'h00);

        // R3 / R4 / R10: every enable value against every single low pin
        for (int e = 0; e < 256; e++) begin
            for (int p = 0; p < 8; p++) begin
                wr(EN_ADDR, 8'(e));
                wr(FL_ADDR, 8'h00);
                @(negedge clk); irq_pin_n = ~(8'h01 << p);
                wait_neg(3);
                exp_f = e[p];
                check(exp_f ? "R3 single pin set" : "R4 disabled pin ignored",
                      {7'd0, irq_req}, {7'd0, exp_f});
                rd(FL_ADDR, rv);
                check("R10 request equals flag", {7'd0, irq_req}, rv);
                irq_pin_n = 8'hFF;
                wait_neg(3);
                wr(FL_ADDR, 8'h00);
                check("R5 clear in sweep", {7'd0, irq_req}, 8'h00);
            end
        end

        // R3 / R4: multi-pin patterns against every enable value
        for (int e = 0; e < 256; e++) begin
            pat = 8'((e * 37 + 11) ^ (e >> 3));
            wr(EN_ADDR, 8'(e));
            wr(FL_ADDR, 8'h00);
            @(negedge clk); irq_pin_n = pat;
            wait_neg(3);
            exp_f = |(~pat & 8'(e));
            check("R3 R4 multi-pin pattern", {7'd0, irq_req}, {7'd0, exp_f});
            irq_pin_n = 8'hFF;
            wait_neg(3);
            wr(FL_ADDR, 8'h00);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule